// File: doc/BRIEF.md
# Multi-Path Operand Forwarding Unit

This block decides, for every operand that a five-stage in-order integer pipeline consumes early, whether the register-file copy is stale and where the fresh value lives. It serves three consumers in one pass. The first is the pair of execute-stage ALU operands. The second is the pair of equality-comparator operands that resolve conditional branches in the decode stage. The third is the store-data input of a store that sits in the memory stage.

The unit is purely combinational. It compares source register indices against the destination indices and control flags held in the later pipeline registers. From that comparison it produces a 2-bit select for each ALU and comparator operand and a 1-bit select for the store data. A thin set of data multiplexers is included, so the forwarded values are available directly on the outputs. Stall generation belongs to a separate controller. For example, a load in the memory stage feeding a branch in decode needs that controller.

Top module: `fwd_unit`

## Requirements
- R1: Each ALU operand select is 2'b00 for the register-file value, 2'b10 for the memory-stage ALU result and 2'b01 for the write-back-stage result, and the matching ALU operand data output carries the selected value.
- R2: When both the memory stage and the write-back stage write the register an ALU operand reads, the select is 2'b10 (the younger, memory-stage producer wins).
- R3: A producer whose destination index is 0 never causes forwarding on any path (ALU, comparator or store data).
- R4: A producer whose register-write flag is low never causes forwarding on any path.
- R5: Each comparator operand uses the same 2-bit encoding and the same priority as R1/R2, and the comparator data output carries the selected value.
- R6: When the memory-stage producer matching a comparator operand is a load (memory-read flag high), that comparator select is 2'b00, even if the write-back stage also matches.
- R7: The store-data select is 1 exactly when the write-back stage holds a register-writing load with a nonzero destination, the memory stage holds a store, and that destination equals the store's second source index. At 1 the store data output is the write-back result, and at 0 it is the pipeline's own store data.
- R8: The store-data select is 0 when the write-back entry is not a load, when the memory-stage entry is not a store, or when the indices differ.
- R9: The operands are resolved independently: within one cycle, different operands may take different sources.
- R10: All selects and data outputs follow the inputs within the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | 5 | Decode-stage first source index |
| id_rs2 | input | 5 | Decode-stage second source index |
| ex_rs1 | input | 5 | Execute-stage first source index |
| ex_rs2 | input | 5 | Execute-stage second source index |
| mem_rd | input | 5 | Memory-stage destination index |
| mem_rs2 | input | 5 | Memory-stage second source index (store data register) |
| mem_regwrite | input | 1 | Memory-stage entry writes a register |
| mem_memread | input | 1 | Memory-stage entry is a load |
| mem_memwrite | input | 1 | Memory-stage entry is a store |
| wb_rd | input | 5 | Write-back-stage destination index |
| wb_regwrite | input | 1 | Write-back-stage entry writes a register |
| wb_memread | input | 1 | Write-back-stage entry is a load |
| id_rf_a | input | 64 | Register-file value for id_rs1 |
| id_rf_b | input | 64 | Register-file value for id_rs2 |
| ex_rf_a | input | 64 | Pipelined register value for ex_rs1 |
| ex_rf_b | input | 64 | Pipelined register value for ex_rs2 |
| mem_alu_result | input | 64 | ALU result held in the memory stage |
| mem_store_data | input | 64 | Store data held in the memory stage |
| wb_result | input | 64 | Final write-back value |
| ex_sel_a | output | 2 | ALU operand A select |
| ex_sel_b | output | 2 | ALU operand B select |
| id_sel_a | output | 2 | Comparator operand A select |
| id_sel_b | output | 2 | Comparator operand B select |
| st_sel | output | 1 | Store-data select |
| ex_opnd_a | output | 64 | Forwarded ALU operand A |
| ex_opnd_b | output | 64 | Forwarded ALU operand B |
| id_cmp_a | output | 64 | Forwarded comparator operand A |
| id_cmp_b | output | 64 | Forwarded comparator operand B |
| mem_wdata | output | 64 | Forwarded store data |

## Verification
The write-back stage can feed the store-data path and an ALU or comparator operand in the same cycle. This happens when a load is followed by a store of the loaded register and then by an instruction that also reads it. The bench provokes this by setting a write-back load whose destination equals both the memory-stage store's data source and an execute or decode source. It then checks that the store select is 1 and the operand select is 2'b01, and that both data outputs carry the write-back value. A second overlap places the same register in both producer stages to confirm that memory-stage priority applies to the ALU while the load block forces the comparator back to the register file.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
    typedef enum logic [1:0] {
        SEL_RF  = 2'b00,
        SEL_WB  = 2'b01,
        SEL_EXM = 2'b10
    } fwd_sel_e;
endpackage

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel
    import fwd_pkg::*;
#(
    parameter int AW       = 5,
    parameter bit LOAD_BLK = 1'b0
) (
    input  logic [AW-1:0] rs,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_regwrite,
    input  logic          mem_memread,
    input  logic [AW-1:0] wb_rd,
    input  logic          wb_regwrite,
    output fwd_sel_e      sel
);
    typedef struct packed {
        logic     mem_hit;
        logic     wb_hit;
        logic     blocked;
        fwd_sel_e sel;
    } sel_st_t;

    sel_st_t st_d;

    always_comb begin
        st_d         = '0;
        st_d.mem_hit = mem_regwrite && (mem_rd != '0) && (mem_rd == rs);
        st_d.wb_hit  = wb_regwrite && (wb_rd != '0) && (wb_rd == rs);
        st_d.blocked = LOAD_BLK && mem_memread && st_d.mem_hit;
        if (st_d.blocked)       st_d.sel = SEL_RF;
        else if (st_d.mem_hit)  st_d.sel = SEL_EXM;
        else if (st_d.wb_hit)   st_d.sel = SEL_WB;
        else                    st_d.sel = SEL_RF;
    end

    assign sel = st_d.sel;

    always_comb begin
        if (sel == SEL_WB)
            assert_wb_sel_needs_write_R4: assert (wb_regwrite && wb_rd == rs);
        if (sel == SEL_EXM)
            assert_exm_sel_needs_write_R4: assert (mem_regwrite && mem_rd == rs);
    end
endmodule

// File: rtl/fwd_store_sel.sv
module fwd_store_sel #(
    parameter int AW = 5
) (
    input  logic [AW-1:0] mem_rs2,
    input  logic          mem_memwrite,
    input  logic [AW-1:0] wb_rd,
    input  logic          wb_regwrite,
    input  logic          wb_memread,
    output logic          sel
);
    typedef struct packed {
        logic ld_ok;
        logic idx_eq;
        logic sel;
    } st_st_t;

    st_st_t st_d;

    always_comb begin
        st_d        = '0;
        st_d.ld_ok  = wb_memread && wb_regwrite && (wb_rd != '0);
        st_d.idx_eq = (wb_rd == mem_rs2);
        st_d.sel    = st_d.ld_ok && mem_memwrite && st_d.idx_eq;
    end

    assign sel = st_d.sel;

    always_comb begin
        if (sel)
            assert_store_fwd_only_ld_sd_R8: assert (wb_memread && mem_memwrite);
    end
endmodule

// File: rtl/fwd_mux3.sv
module fwd_mux3
    import fwd_pkg::*;
#(
    parameter int DW = 64
) (
    input  fwd_sel_e      sel,
    input  logic [DW-1:0] rf_val,
    input  logic [DW-1:0] exm_val,
    input  logic [DW-1:0] wb_val,
    output logic [DW-1:0] y
);
    always_comb begin
        unique case (sel)
            SEL_EXM: y = exm_val;
            SEL_WB:  y = wb_val;
            default: y = rf_val;
        endcase
    end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int AW = 5,
    parameter int DW = 64
) (
    input  logic [AW-1:0] id_rs1,
    input  logic [AW-1:0] id_rs2,
    input  logic [AW-1:0] ex_rs1,
    input  logic [AW-1:0] ex_rs2,
    input  logic [AW-1:0] mem_rd,
    input  logic [AW-1:0] mem_rs2,
    input  logic          mem_regwrite,
    input  logic          mem_memread,
    input  logic          mem_memwrite,
    input  logic [AW-1:0] wb_rd,
    input  logic          wb_regwrite,
    input  logic          wb_memread,
    input  logic [DW-1:0] id_rf_a,
    input  logic [DW-1:0] id_rf_b,
    input  logic [DW-1:0] ex_rf_a,
    input  logic [DW-1:0] ex_rf_b,
    input  logic [DW-1:0] mem_alu_result,
    input  logic [DW-1:0] mem_store_data,
    input  logic [DW-1:0] wb_result,
    output logic [1:0]    ex_sel_a,
    output logic [1:0]    ex_sel_b,
    output logic [1:0]    id_sel_a,
    output logic [1:0]    id_sel_b,
    output logic          st_sel,
    output logic [DW-1:0] ex_opnd_a,
    output logic [DW-1:0] ex_opnd_b,
    output logic [DW-1:0] id_cmp_a,
    output logic [DW-1:0] id_cmp_b,
    output logic [DW-1:0] mem_wdata
);
    localparam int NOPS = 2;
    localparam int NGRP = 2;  // group 0: execute ALU, group 1: decode comparator

    logic [AW-1:0] rs_arr  [NGRP][NOPS];
    logic [DW-1:0] rf_arr  [NGRP][NOPS];
    fwd_sel_e      sel_arr [NGRP][NOPS];
    logic [DW-1:0] out_arr [NGRP][NOPS];
    logic          st_sel_d;

    assign rs_arr[0][0] = ex_rs1;
    assign rs_arr[0][1] = ex_rs2;
    assign rs_arr[1][0] = id_rs1;
    assign rs_arr[1][1] = id_rs2;
    assign rf_arr[0][0] = ex_rf_a;
    assign rf_arr[0][1] = ex_rf_b;
    assign rf_arr[1][0] = id_rf_a;
    assign rf_arr[1][1] = id_rf_b;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        for (genvar k = 0; k < NOPS; k++) begin : g_op
            fwd_operand_sel #(.AW(AW), .LOAD_BLK(g == 1)) i_sel (
                .rs           (rs_arr[g][k]),
                .mem_rd       (mem_rd),
                .mem_regwrite (mem_regwrite),
                .mem_memread  (mem_memread),
                .wb_rd        (wb_rd),
                .wb_regwrite  (wb_regwrite),
                .sel          (sel_arr[g][k])
            );
            fwd_mux3 #(.DW(DW)) i_mux (
                .sel     (sel_arr[g][k]),
                .rf_val  (rf_arr[g][k]),
                .exm_val (mem_alu_result),
                .wb_val  (wb_result),
                .y       (out_arr[g][k])
            );
        end
    end

    fwd_store_sel #(.AW(AW)) i_store_sel (
        .mem_rs2      (mem_rs2),
        .mem_memwrite (mem_memwrite),
        .wb_rd        (wb_rd),
        .wb_regwrite  (wb_regwrite),
        .wb_memread   (wb_memread),
        .sel          (st_sel_d)
    );

    assign ex_sel_a  = sel_arr[0][0];
    assign ex_sel_b  = sel_arr[0][1];
    assign id_sel_a  = sel_arr[1][0];
    assign id_sel_b  = sel_arr[1][1];
    assign ex_opnd_a = out_arr[0][0];
    assign ex_opnd_b = out_arr[0][1];
    assign id_cmp_a  = out_arr[1][0];
    assign id_cmp_b  = out_arr[1][1];
    assign st_sel    = st_sel_d;
    assign mem_wdata = st_sel_d ? wb_result : mem_store_data;

    always_comb begin
        if (ex_sel_a != SEL_RF)
            assert_no_fwd_from_x0_R3: assert (ex_rs1 != '0);
        if (mem_regwrite && mem_rd != '0 && mem_rd == ex_rs1)
            assert_exm_priority_R2: assert (ex_sel_a == SEL_EXM);
        if (mem_memread && mem_regwrite && mem_rd != '0 && mem_rd == id_rs1)
            assert_cmp_load_block_R6: assert (id_sel_a == SEL_RF);
        if (id_sel_b == SEL_EXM)
            assert_cmp_exm_data_R5: assert (id_cmp_b == mem_alu_result);
        if (st_sel)
            assert_store_fwd_data_R7: assert (mem_wdata == wb_result && wb_rd == mem_rs2);
        if (ex_sel_b == SEL_WB)
            assert_wb_data_R1: assert (ex_opnd_b == wb_result);
    end
endmodule

// File: tb/test_fwd_unit.sv
`timescale 1ns/1ps
module test_fwd_unit;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [4:0]  id_rs1, id_rs2, ex_rs1, ex_rs2, mem_rd, mem_rs2, wb_rd;
    logic        mem_regwrite, mem_memread, mem_memwrite, wb_regwrite, wb_memread;
    logic [63:0] id_rf_a, id_rf_b, ex_rf_a, ex_rf_b, mem_alu_result, mem_store_data, wb_result;
    logic [1:0]  ex_sel_a, ex_sel_b, id_sel_a, id_sel_b;
    logic        st_sel;
    logic [63:0] ex_opnd_a, ex_opnd_b, id_cmp_a, id_cmp_b, mem_wdata;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    localparam logic [63:0] V_IDA = 64'h1111_0000_0000_00A1;
    localparam logic [63:0] V_IDB = 64'h1111_0000_0000_00B2;
    localparam logic [63:0] V_EXA = 64'h2222_0000_0000_00A3;
    localparam logic [63:0] V_EXB = 64'h2222_0000_0000_00B4;
    localparam logic [63:0] V_EXM = 64'h3333_CAFE_0000_0005;
    localparam logic [63:0] V_ST  = 64'h4444_0000_5700_0006;
    localparam logic [63:0] V_WB  = 64'h5555_BEEF_0000_0007;

    fwd_unit i_fwd_unit (.*);

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        @(posedge clk);
        {id_rs1, id_rs2, ex_rs1, ex_rs2, mem_rd, mem_rs2, wb_rd} = '0;
        {mem_regwrite, mem_memread, mem_memwrite, wb_regwrite, wb_memread} = '0;
        id_rf_a = V_IDA; id_rf_b = V_IDB; ex_rf_a = V_EXA; ex_rf_b = V_EXB;
        mem_alu_result = V_EXM; mem_store_data = V_ST; wb_result = V_WB;
    endtask

    task automatic t_reset();
        idle();
        @(negedge clk);
        chk("R1", "idle ex_sel_a", 64'(ex_sel_a), 64'd0);
        chk("R1", "idle ex_opnd_a", ex_opnd_a, V_EXA);
        chk("R5", "idle id_cmp_b", id_cmp_b, V_IDB);
        chk("R7", "idle mem_wdata", mem_wdata, V_ST);
    endtask

    task automatic t_alu_basic();
        idle();
        ex_rs1 = 5'd5; ex_rs2 = 5'd6;
        mem_rd = 5'd5; mem_regwrite = 1'b1;
        wb_rd = 5'd6; wb_regwrite = 1'b1;
        @(negedge clk);
        chk("R1", "ex_sel_a exm", 64'(ex_sel_a), 64'd2);
        chk("R1", "ex_opnd_a exm", ex_opnd_a, V_EXM);
        chk("R9", "ex_sel_b wb", 64'(ex_sel_b), 64'd1);
        chk("R9", "ex_opnd_b wb", ex_opnd_b, V_WB);
        // R10: change a source index mid-cycle, outputs follow at once
        #1 ex_rs1 = 5'd9;
        #1 chk("R10", "ex_sel_a after change", 64'(ex_sel_a), 64'd0);
        chk("R10", "ex_opnd_a after change", ex_opnd_a, V_EXA);
    endtask

    task automatic t_alu_priority();
        idle();
        ex_rs1 = 5'd7; ex_rs2 = 5'd7;
        mem_rd = 5'd7; mem_regwrite = 1'b1;
        wb_rd = 5'd7; wb_regwrite = 1'b1;
        @(negedge clk);
        chk("R2", "double match ex_sel_a", 64'(ex_sel_a), 64'd2);
        chk("R2", "double match ex_opnd_b", ex_opnd_b, V_EXM);
    endtask

    task automatic t_x0();
        idle();
        {id_rs1, id_rs2, ex_rs1, ex_rs2, mem_rd, mem_rs2, wb_rd} = '0;
        mem_regwrite = 1'b1; mem_memwrite = 1'b1;
        wb_regwrite = 1'b1; wb_memread = 1'b1;
        @(negedge clk);
        chk("R3", "x0 ex_sel_a", 64'(ex_sel_a), 64'd0);
        chk("R3", "x0 id_sel_b", 64'(id_sel_b), 64'd0);
        chk("R3", "x0 st_sel", 64'(st_sel), 64'd0);
        chk("R3", "x0 mem_wdata", mem_wdata, V_ST);
        // only write-back producer at x0 while mem stage idle
        mem_regwrite = 1'b0;
        @(negedge clk);
        chk("R3", "x0 wb ex_sel_b", 64'(ex_sel_b), 64'd0);
    endtask

    task automatic t_nowrite();
        idle();
        ex_rs1 = 5'd3; id_rs2 = 5'd4; mem_rs2 = 5'd4; mem_memwrite = 1'b1;
        mem_rd = 5'd3; wb_rd = 5'd4; wb_memread = 1'b1;
        @(negedge clk);
        chk("R4", "nowrite ex_sel_a", 64'(ex_sel_a), 64'd0);
        chk("R4", "nowrite id_sel_b", 64'(id_sel_b), 64'd0);
        chk("R4", "nowrite st_sel", 64'(st_sel), 64'd0);
        chk("R4", "nowrite id_cmp_b", id_cmp_b, V_IDB);
    endtask

    task automatic t_branch();
        idle();
        id_rs1 = 5'd10; id_rs2 = 5'd11;
        mem_rd = 5'd10; mem_regwrite = 1'b1;
        wb_rd = 5'd11; wb_regwrite = 1'b1;
        @(negedge clk);
        chk("R5", "cmp a exm", 64'(id_sel_a), 64'd2);
        chk("R5", "cmp a data", id_cmp_a, V_EXM);
        chk("R5", "cmp b wb", 64'(id_sel_b), 64'd1);
        chk("R5", "cmp b data", id_cmp_b, V_WB);
        wb_rd = 5'd10;
        id_rs2 = 5'd10;
        @(negedge clk);
        chk("R5", "cmp double match", 64'(id_sel_b), 64'd2);
    endtask

    task automatic t_branch_load();
        idle();
        id_rs1 = 5'd12; ex_rs1 = 5'd12; id_rs2 = 5'd13;
        mem_rd = 5'd12; mem_regwrite = 1'b1; mem_memread = 1'b1;
        wb_rd = 5'd12; wb_regwrite = 1'b1;
        @(negedge clk);
        chk("R6", "cmp load block sel", 64'(id_sel_a), 64'd0);
        chk("R6", "cmp load block data", id_cmp_a, V_IDA);
        chk("R2", "alu still exm with load", 64'(ex_sel_a), 64'd2);
        wb_rd = 5'd13;
        @(negedge clk);
        chk("R6", "other cmp operand wb", 64'(id_sel_b), 64'd1);
    endtask

    task automatic t_store();
        idle();
        wb_rd = 5'd9; wb_regwrite = 1'b1; wb_memread = 1'b1;
        mem_rs2 = 5'd9; mem_memwrite = 1'b1; mem_rd = 5'd0;
        ex_rs1 = 5'd9; id_rs2 = 5'd9;
        @(negedge clk);
        chk("R7", "store fwd sel", 64'(st_sel), 64'd1);
        chk("R7", "store fwd data", mem_wdata, V_WB);
        chk("R9", "same cycle alu wb", 64'(ex_sel_a), 64'd1);
        chk("R9", "same cycle cmp wb data", id_cmp_b, V_WB);
    endtask

    task automatic t_store_neg();
        idle();
        wb_rd = 5'd9; wb_regwrite = 1'b1; wb_memread = 1'b0;
        mem_rs2 = 5'd9; mem_memwrite = 1'b1;
        @(negedge clk);
        chk("R8", "wb not load", 64'(st_sel), 64'd0);
        wb_memread = 1'b1; mem_memwrite = 1'b0;
        @(negedge clk);
        chk("R8", "mem not store", 64'(st_sel), 64'd0);
        mem_memwrite = 1'b1; mem_rs2 = 5'd8;
        @(negedge clk);
        chk("R8", "index mismatch", 64'(st_sel), 64'd0);
        chk("R8", "index mismatch data", mem_wdata, V_ST);
    endtask

    initial begin
        t_reset();
        t_alu_basic();
        t_alu_priority();
        t_x0();
        t_nowrite();
        t_branch();
        t_branch_load();
        t_store();
        t_store_neg();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule